// File: doc/BRIEF.md
# Programmable interval counter channel

One down-counter channel of an interval timer. All logic runs on the system clock `clk_i`. The timer's input clock arrives as a one-cycle enable `tick_i`, so each high `tick_i` is one count step. A separate register block writes the initial count, the mode code and the decimal select, and pulses `load_i`. The channel then shapes `out_o` according to one of six counting behaviours: terminal-count flag, gate-triggered one-shot, periodic rate pulse, square wave, software strobe and gate-triggered strobe. The live count is always visible on `count_o`, so a read path can latch it.

The gate input does different jobs depending on the mode. In the free-running and software-started modes it pauses counting. In the two triggered modes a rising edge starts or restarts the period. A loaded count of zero stands for the largest period the counter can hold. With the decimal select set, the count steps through four BCD digits instead of 16 binary bits.

Top module: `interval_counter_channel`

## Requirements
- R1: `mode_i` is captured on `load_i` and selects the behaviour. Codes 0 to 5 are the six behaviours: 0 terminal flag, 1 triggered one-shot, 2 rate, 3 square wave, 4 software strobe, 5 triggered strobe. Code 6 acts exactly as code 2, and code 7 acts exactly as code 3.
- R2: Mode 0: after a load `out_o` is low. The tick that finds the count at 1 drives `out_o` high and the count to 0. After that, further ticks change nothing until the next load.
- R3: Modes 1 and 5 ignore ticks after a load until a rising edge is seen on `gate_i`. The first tick after that edge copies the initial count into the counter. In mode 1 this also drives `out_o` low. A later rising edge restarts the period the same way. In mode 1, `out_o` goes high again on the tick that finds the count at 1.
- R4: Mode 2: `out_o` is low exactly while the count is 1. The tick that finds the count at 1 reloads the initial count and drives `out_o` high, so the period is N ticks.
- R5: Modes 3 and 7 decrement the count by 2 per tick. A tick that finds the count at 1 or 2 toggles `out_o` and reloads the counter. Entering the low half it loads N with bit 0 cleared; entering the high half it loads N. This makes the high half ceil(N/2) ticks and the low half floor(N/2) ticks.
- R6: Mode 4: after a load `out_o` is high. The tick that finds the count at 1 drives the count to 0 and `out_o` low. The next tick returns `out_o` high, and nothing repeats until the next load.
- R7: Mode 5 behaves like mode 4, but it is started (and restarted) by a gate rising edge as described in R3, and `out_o` stays high at the trigger.
- R8: When `bcd_i` is 1 at load, the count steps as four BCD digits, with a borrow from each digit into the next (0x0010 minus 1 is 0x0009; minus 2 is 0x0008).
- R9: A loaded count of 0 is the maximum period. Its first tick gives 0xFFFF in binary or 0x9999 in BCD.
- R10: In modes 0, 2, 3 and 4, ticks have no effect while `gate_i` is low. In modes 2 and 3, a low gate also forces `out_o` high and holds the counter at the initial count.
- R11: Reset leaves `out_o` high, `count_o` at 0 and the channel idle.
- R12: `load_i` places `count_i` on `count_o` on the next clock edge. If a load and a tick fall in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count enable (timer input clock) |
| gate_i | input | 1 | Gate level |
| mode_i | input | 3 | Mode code, captured on load |
| bcd_i | input | 1 | Decimal counting select, captured on load |
| count_i | input | 16 | Initial count |
| load_i | input | 1 | Load strobe |
| count_o | output | 16 | Live count |
| out_o | output | 1 | Channel output |

## Verification
A count load and a count step can land on the same clock edge. The bench provokes this by raising `load_i` and `tick_i` together while the counter is running. It then requires that `count_o` shows the freshly loaded value, not the value one below it, and that the next tick lowers it by exactly one. The same kind of overlap, a gate rising edge arriving while a triggered period is already running, is judged by checking that the count returns to the initial value on the following tick.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [2:0] {
    M_TC        = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } mode_e;

  // codes 6 and 7 alias 2 and 3
  function automatic mode_e fold_mode(input logic [2:0] code);
    return code[1] ? mode_e'({1'b0, code[1:0]}) : mode_e'(code);
  endfunction

  function automatic logic is_trig(input mode_e m);
    return (m == M_ONESHOT) || (m == M_HW_STROBE);
  endfunction
endpackage

// File: rtl/icc_stepper.sv
module icc_stepper #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          bcd_i,
  input  logic          dbl_i,
  output logic [CW-1:0] nxt_o
);
  localparam int unsigned ND = CW / 4;

  logic [CW-1:0] bin_nxt;
  logic [CW-1:0] bcd_nxt;
  logic [1:0]    amt [ND];

  assign bin_nxt = cnt_i - (dbl_i ? CW'(2) : CW'(1));
  assign amt[0]  = dbl_i ? 2'd2 : 2'd1;

  for (genvar g = 0; g < ND; g++) begin : g_dig
    logic [4:0] d;
    assign d = {1'b0, cnt_i[4*g +: 4]} - {3'd0, amt[g]};
    assign bcd_nxt[4*g +: 4] = d[4] ? (d[3:0] + 4'd10) : d[3:0];
    if (g < ND - 1) begin : g_borrow
      assign amt[g+1] = {1'b0, d[4]};
    end
  end

  assign nxt_o = bcd_i ? bcd_nxt : bin_nxt;
endmodule

// File: rtl/icc_gate_edge.sv
module icc_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  // reset high so a gate held high out of reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel
  import icc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic [2:0]    mode_i,
  input  logic          bcd_i,
  input  logic [CW-1:0] count_i,
  input  logic          load_i,
  output logic [CW-1:0] count_o,
  output logic          out_o
);
  localparam int unsigned ND = CW / 4;
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  mode_e         mode_q, load_mode;
  logic          bcd_q, run_q, pend_q, out_q;
  logic [CW-1:0] init_q, cnt_q, nxt;
  logic          rise, gated, forced, adv, at_one, at_two;

  function automatic logic bcd_ok(input logic [CW-1:0] v);
    for (int i = 0; i < ND; i++)
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  icc_gate_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (rise)
  );

  icc_stepper #(.CW(CW)) u_step (
    .cnt_i (cnt_q),
    .bcd_i (bcd_q),
    .dbl_i (mode_q == M_SQUARE),
    .nxt_o (nxt)
  );

  assign load_mode = fold_mode(mode_i);
  assign gated     = !is_trig(mode_q);
  assign forced    = run_q && !gate_i && (mode_q == M_RATE || mode_q == M_SQUARE);
  assign adv       = tick_i && run_q && (!gated || gate_i);
  assign at_one    = (cnt_q == ONE);
  assign at_two    = (cnt_q == TWO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_TC;
      bcd_q  <= 1'b0;
      init_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      out_q  <= 1'b1;
    end else if (load_i) begin
      mode_q <= load_mode;
      bcd_q  <= bcd_i;
      init_q <= count_i;
      cnt_q  <= count_i;
      pend_q <= 1'b0;
      run_q  <= !is_trig(load_mode);
      out_q  <= (load_mode != M_TC);
    end else begin
      if (is_trig(mode_q) && rise) pend_q <= 1'b1;
      if (is_trig(mode_q) && pend_q && tick_i) begin
        cnt_q  <= init_q;
        run_q  <= 1'b1;
        pend_q <= rise;
        out_q  <= (mode_q != M_ONESHOT);
      end else if (forced) begin
        out_q <= 1'b1;
        cnt_q <= init_q;
      end else if (adv) begin
        unique case (mode_q)
          M_TC, M_ONESHOT: begin
            cnt_q <= nxt;
            if (at_one) begin
              out_q <= 1'b1;
              run_q <= 1'b0;
            end
          end
          M_SW_STROBE, M_HW_STROBE: begin
            cnt_q <= nxt;
            if (at_one) begin
              out_q <= 1'b0;
              run_q <= 1'b0;
            end
          end
          M_RATE: begin
            if (at_one) begin
              cnt_q <= init_q;
              out_q <= 1'b1;
            end else begin
              cnt_q <= nxt;
              out_q <= (nxt != ONE);
            end
          end
          M_SQUARE: begin
            if (at_one || at_two) begin
              out_q <= ~out_q;
              // odd count: low half one tick shorter
              cnt_q <= out_q ? (init_q & ~ONE) : init_q;
            end else begin
              cnt_q <= nxt;
            end
          end
          default: cnt_q <= cnt_q;
        endcase
      end else if (tick_i && !out_q && !run_q &&
                   (mode_q == M_SW_STROBE || mode_q == M_HW_STROBE)) begin
        out_q <= 1'b1;
      end
    end
  end

  assign count_o = cnt_q;
  assign out_o   = out_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(count_i)); // R12

  AST_RATE_LOW_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_RATE && !out_o) |-> cnt_q == ONE); // R4

  AST_GATE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && run_q && !gate_i && (mode_q == M_TC || mode_q == M_SW_STROBE))
      |=> $stable(count_o)); // R10

  AST_IDLE_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !run_q && !pend_q) |=> $stable(count_o)); // R3

  AST_PEND_TRIG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (mode_q == M_ONESHOT || mode_q == M_HW_STROBE)); // R3

  AST_SQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && run_q && gate_i && mode_q == M_SQUARE && !at_one && !at_two)
      |=> $stable(out_o)); // R5

  AST_BCD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && bcd_q && bcd_ok(cnt_q) && bcd_ok(init_q)) |=> bcd_ok(count_o)); // R8
endmodule

// File: tb/interval_counter_channel_test.sv
module interval_counter_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] TK = 2'd0, LD = 2'd1, GT = 2'd2;
  localparam int NV = 63;

  // {req, op, mode, bcd, data, exp_out, exp_cnt}
  localparam logic [42:0] VEC [NV] = '{
    {4'd2, LD, 3'd0, 1'b0, 16'h0003, 1'b0, 16'h0003}, // R2
    {4'd2, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0002},
    {4'd10, GT, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0002}, // R10
    {4'd10, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0002},
    {4'd10, GT, 3'd0, 1'b0, 16'h0001, 1'b0, 16'h0002},
    {4'd2, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0001},
    {4'd2, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {4'd2, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {4'd4, LD, 3'd2, 1'b0, 16'h0003, 1'b1, 16'h0003}, // R4
    {4'd4, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0002},
    {4'd4, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0001},
    {4'd4, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0003},
    {4'd4, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0002},
    {4'd4, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0001},
    {4'd10, GT, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0003}, // R10
    {4'd10, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0003},
    {4'd10, GT, 3'd0, 1'b0, 16'h0001, 1'b1, 16'h0003},
    {4'd1, LD, 3'd6, 1'b0, 16'h0002, 1'b1, 16'h0002}, // R1
    {4'd1, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0001},
    {4'd1, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0002},
    {4'd5, LD, 3'd3, 1'b0, 16'h0005, 1'b1, 16'h0005}, // R5
    {4'd5, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0003},
    {4'd5, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0001},
    {4'd5, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0004},
    {4'd5, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0002},
    {4'd5, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0005},
    {4'd1, LD, 3'd7, 1'b0, 16'h0004, 1'b1, 16'h0004}, // R1
    {4'd1, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0002},
    {4'd1, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0004},
    {4'd1, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0002},
    {4'd1, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0004},
    {4'd6, LD, 3'd4, 1'b0, 16'h0002, 1'b1, 16'h0002}, // R6
    {4'd6, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0001},
    {4'd6, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0000},
    {4'd6, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {4'd6, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {4'd3, LD, 3'd1, 1'b0, 16'h0002, 1'b1, 16'h0002}, // R3
    {4'd3, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0002},
    {4'd3, GT, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0002},
    {4'd3, GT, 3'd0, 1'b0, 16'h0001, 1'b1, 16'h0002},
    {4'd3, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0002},
    {4'd3, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0001},
    {4'd3, GT, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0001},
    {4'd3, GT, 3'd0, 1'b0, 16'h0001, 1'b0, 16'h0001},
    {4'd3, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0002},
    {4'd3, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0001},
    {4'd3, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {4'd7, LD, 3'd5, 1'b0, 16'h0002, 1'b1, 16'h0002}, // R7
    {4'd7, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0002},
    {4'd7, GT, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0002},
    {4'd7, GT, 3'd0, 1'b0, 16'h0001, 1'b1, 16'h0002},
    {4'd7, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0002},
    {4'd7, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0001},
    {4'd7, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0000},
    {4'd7, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {4'd8, LD, 3'd0, 1'b1, 16'h0010, 1'b0, 16'h0010}, // R8
    {4'd8, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0009},
    {4'd8, LD, 3'd3, 1'b1, 16'h0010, 1'b1, 16'h0010},
    {4'd8, TK, 3'd0, 1'b0, 16'h0000, 1'b1, 16'h0008},
    {4'd9, LD, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0000}, // R9
    {4'd9, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'hFFFF},
    {4'd9, LD, 3'd0, 1'b1, 16'h0000, 1'b0, 16'h0000},
    {4'd9, TK, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h9999}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        gate = 1'b1;
  logic [2:0]  mode = 3'd0;
  logic        bcd = 1'b0;
  logic [15:0] cnt_in = '0;
  logic        load = 1'b0;
  logic [15:0] cnt_out;
  logic        out;
  int          checks = 0;
  int          fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  interval_counter_channel uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .gate_i  (gate),
    .mode_i  (mode),
    .bcd_i   (bcd),
    .count_i (cnt_in),
    .load_i  (load),
    .count_o (cnt_out),
    .out_o   (out)
  );

  task automatic check(input int req, input logic eo, input logic [15:0] ec);
    checks++;
    if (out !== eo || cnt_out !== ec) begin
      fails++;
      $display("FAIL R%0d: out=%b count=%h expected out=%b count=%h", req, out, cnt_out, eo, ec);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [2:0] m, input logic b,
                      input logic [15:0] d);
    @(negedge clk);
    case (op)
      TK: tick = 1'b1;
      LD: begin load = 1'b1; mode = m; bcd = b; cnt_in = d; end
      default: gate = d[0];
    endcase
    @(negedge clk);
    tick = 1'b0;
    load = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(11, 1'b1, 16'h0000); // R11 reset state
    rst_n = 1'b1;
    step(TK, 3'd0, 1'b0, 16'h0000);
    check(11, 1'b1, 16'h0000); // R11 idle ignores ticks

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][38:37], VEC[i][36:34], VEC[i][33], VEC[i][32:17]);
      check(int'(VEC[i][42:39]), VEC[i][16], VEC[i][15:0]);
    end

    // R12: load and tick in the same cycle, load wins
    step(LD, 3'd0, 1'b0, 16'h0009);
    step(TK, 3'd0, 1'b0, 16'h0000);
    @(negedge clk);
    tick = 1'b1; load = 1'b1; mode = 3'd0; cnt_in = 16'h0007;
    @(negedge clk);
    tick = 1'b0; load = 1'b0;
    check(12, 1'b0, 16'h0007);
    step(TK, 3'd0, 1'b0, 16'h0000);
    check(12, 1'b0, 16'h0006);

    // R3: retrigger during a running one-shot restarts from the initial count
    step(LD, 3'd1, 1'b0, 16'h0004);
    step(GT, 3'd0, 1'b0, 16'h0000);
    step(GT, 3'd0, 1'b0, 16'h0001);
    step(TK, 3'd0, 1'b0, 16'h0000);
    step(TK, 3'd0, 1'b0, 16'h0000);
    step(TK, 3'd0, 1'b0, 16'h0000);
    check(3, 1'b0, 16'h0002);
    step(GT, 3'd0, 1'b0, 16'h0000);
    step(GT, 3'd0, 1'b0, 16'h0001);
    step(TK, 3'd0, 1'b0, 16'h0000);
    check(3, 1'b0, 16'h0004);

    // R5: odd count 3 gives a high half of 2 ticks and a low half of 1 tick
    step(LD, 3'd3, 1'b0, 16'h0003);
    step(TK, 3'd0, 1'b0, 16'h0000);
    check(5, 1'b1, 16'h0001);
    step(TK, 3'd0, 1'b0, 16'h0000);
    check(5, 1'b0, 16'h0002);
    step(TK, 3'd0, 1'b0, 16'h0000);
    check(5, 1'b1, 16'h0003);

    // R11: reset in mid-count returns to the idle state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(11, 1'b1, 16'h0000);
    rst_n = 1'b1;

    finish_run();
  end
endmodule